// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Comparator

This block is the phase-frequency detector of a digital PLL. It compares a feedback signal (the divided oscillator output) against a reference signal. Both signals are sampled in a synchronous system clock domain.

The output has three levels:

- **Drive high** (`pd_oe`=1, `pd_drive`=1) when the feedback edge leads.
- **Drive low** (`pd_oe`=1, `pd_drive`=0) when the reference edge leads.
- **Released** (`pd_oe`=0) otherwise. This models the three-state node that feeds an external loop filter.

Only rising edges matter. When the two frequencies differ, the detector pushes in one direction only, toward the faster feedback or away from it, until the edges line up.

A lock flag reports a settled loop. It sets after a programmable number of consecutive edge pairs that arrived within a window of system clocks. Any drive interval that outlasts that window clears it. Edge timing is resolved to one system clock period, and each input passes through a synchronizer before edge detection.

Top module: `pfd_comparator`

## Requirements
- R1: A synchronous active-high `rst` forces `pd_oe`=0, `pd_drive`=0 and `lock_det`=0 after the clock edge on which it is sampled, and clears the pair counter.
- R2: A rising input level first sampled at clock edge k is acted on at edge k+2, so the outputs change after edge k+2 (2 synchronizer stages plus 1 edge-detect stage).
- R3: Falling edges of either input never change any output, so the input duty cycles do not affect the result.
- R4: While released, a feedback rising edge alone gives drive high (`pd_oe`=1, `pd_drive`=1), and a reference rising edge alone gives drive low (`pd_oe`=1, `pd_drive`=0).
- R5: While driving high, a reference edge without a feedback edge releases the output. While driving low, a feedback edge without a reference edge releases it. Both edges in the same cycle keep the present level and start a new interval.
- R6: While driving high, further feedback edges alone leave the output unchanged. While driving low, further reference edges alone leave it unchanged.
- R7: Feedback and reference rising edges detected in the same cycle while released leave the output released.
- R8: `pd_drive` is 0 whenever `pd_oe` is 0.
- R9: An edge pair is good in two cases: coincident edges while released, or a drive interval that ends after at most `win_cfg` driven cycles. `lock_det` rises once LOCK_PAIRS (default 4) consecutive good pairs have been seen.
- R10: A drive interval that lasts more than `win_cfg` cycles clears `lock_det` and the pair count.
- R11: With equal periods and the feedback leading by d cycles, the output is driven high for exactly d cycles per period and never low. With a lag of d cycles it is driven low for exactly d cycles per period and never high. A faster feedback input gives only high drive, and a slower one gives only low drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_in | input | 1 | Feedback input (asynchronous) |
| ref_in | input | 1 | Reference input (asynchronous) |
| win_cfg | input | WIN_W | Lock window in system clock cycles |
| pd_drive | output | 1 | Drive level, valid while pd_oe is 1 |
| pd_oe | output | 1 | Output enable; 0 means released |
| lock_det | output | 1 | Lock indicator |

## Verification
The bench goes after four corner cases:

- **Coincident edges.** A detector that lets one coincident edge win would pulse the output and never report lock with a zero window.
- **Both edges while driving.** A detector that released the output here would drop half of a frequency error and steer in the wrong direction.
- **Duty cycle.** Changing the duty cycle must not change the measured drive time. A design that acts on falling edges would show drive in the wrong direction.
- **Lock window.** Phase offsets just inside and just outside `win_cfg` must set and clear lock respectively, and a long drive after lock must drop it. An off-by-one in the interval count would show up as lock flipping at the wrong offset.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef enum logic [1:0] {
      PFD_REL = 2'd0,
      PFD_UP  = 2'd1,
      PFD_DN  = 2'd2
   } pfd_state_e;
endpackage

// File: rtl/pfd_sync_edge.sv
// Synchronizer chain followed by a rising-edge detector.
module pfd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] sh;
   logic              last;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last <= 1'b0;
      else     last <= sh[STAGES-1];
   end

   assign rise = sh[STAGES-1] & ~last;
endmodule

// File: rtl/pfd_core.sv
// Three-state detector state machine.
module pfd_core
   import pfd_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       a_rise,
   input  logic       b_rise,
   output pfd_state_e st,
   output pfd_state_e st_nxt
);
   always_comb begin
      st_nxt = st;
      unique case (st)
         PFD_REL: begin
            if (a_rise && !b_rise)      st_nxt = PFD_UP;
            else if (b_rise && !a_rise) st_nxt = PFD_DN;
         end
         PFD_UP: begin
            if (b_rise && !a_rise) st_nxt = PFD_REL;
         end
         PFD_DN: begin
            if (a_rise && !b_rise) st_nxt = PFD_REL;
         end
         default: st_nxt = PFD_REL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= PFD_REL;
      else     st <= st_nxt;
   end
endmodule

// File: rtl/pfd_lock.sv
// Interval length counter and consecutive good-pair counter.
module pfd_lock
   import pfd_pkg::*;
#(
   parameter int WIN_W      = 4,
   parameter int LOCK_PAIRS = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             a_rise,
   input  logic             b_rise,
   input  pfd_state_e       st,
   input  pfd_state_e       st_nxt,
   input  logic [WIN_W-1:0] win,
   output logic             lock
);
   localparam int RUN_W = WIN_W + 1;
   localparam int CNT_W = $clog2(LOCK_PAIRS + 1);
   localparam logic [RUN_W-1:0] RUN_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOCK_PAIRS);

   logic [RUN_W-1:0] run_len;
   logic [CNT_W-1:0] pair_cnt;
   logic             closing, coinc, good, too_long;
   logic [RUN_W-1:0] win_ext;

   assign win_ext  = {1'b0, win};
   assign closing  = ((st == PFD_UP) && b_rise) || ((st == PFD_DN) && a_rise);
   assign coinc    = (st == PFD_REL) && a_rise && b_rise;
   assign good     = coinc || (closing && (run_len <= win_ext));
   assign too_long = (st != PFD_REL) && (run_len > win_ext);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_len <= '0;
      end else if (st_nxt == PFD_REL) begin
         run_len <= '0;
      end else if ((st == PFD_REL) || closing) begin
         run_len <= RUN_W'(1);
      end else if (run_len != RUN_MAX) begin
         run_len <= run_len + RUN_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst || too_long) begin
         pair_cnt <= '0;
      end else if (good && (pair_cnt != CNT_FULL)) begin
         pair_cnt <= pair_cnt + CNT_W'(1);
      end
   end

   assign lock = (pair_cnt == CNT_FULL);
endmodule

// File: rtl/pfd_comparator.sv
module pfd_comparator
   import pfd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WIN_W       = 4,
   parameter int LOCK_PAIRS  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fb_in,
   input  logic             ref_in,
   input  logic [WIN_W-1:0] win_cfg,
   output logic             pd_drive,
   output logic             pd_oe,
   output logic             lock_det
);
   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (WIN_W < 1 || WIN_W > 16) begin : g_bad_win
         $error("WIN_W must lie in 1..16");
      end
      if (LOCK_PAIRS < 1) begin : g_bad_pairs
         $error("LOCK_PAIRS must be at least 1");
      end
   endgenerate

   logic       fb_rise, ref_rise;
   pfd_state_e st, st_nxt;

   pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_fb_edge (
      .clk(clk), .rst(rst), .din(fb_in), .rise(fb_rise)
   );

   pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_ref_edge (
      .clk(clk), .rst(rst), .din(ref_in), .rise(ref_rise)
   );

   pfd_core u_core (
      .clk(clk), .rst(rst), .a_rise(fb_rise), .b_rise(ref_rise),
      .st(st), .st_nxt(st_nxt)
   );

   pfd_lock #(.WIN_W(WIN_W), .LOCK_PAIRS(LOCK_PAIRS)) u_lock (
      .clk(clk), .rst(rst), .a_rise(fb_rise), .b_rise(ref_rise),
      .st(st), .st_nxt(st_nxt), .win(win_cfg), .lock(lock_det)
   );

   assign pd_oe    = (st != PFD_REL);
   assign pd_drive = (st == PFD_UP);
endmodule

// File: rtl/pfd_comparator_chk.sv
module pfd_comparator_chk (
   input logic clk,
   input logic rst,
   input logic a_rise,
   input logic b_rise,
   input logic oe,
   input logic drive,
   input logic lock
);
   // R1
   rst_release_chk: assert property (@(posedge clk) rst |=> (!oe && !drive && !lock));

   // R3
   quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!a_rise && !b_rise) |=> ($stable(oe) && $stable(drive)));

   // R4
   a_only_up_chk: assert property (@(posedge clk) disable iff (rst)
      (!oe && a_rise && !b_rise) |=> (oe && drive));

   // R4
   b_only_dn_chk: assert property (@(posedge clk) disable iff (rst)
      (!oe && b_rise && !a_rise) |=> (oe && !drive));

   // R5
   up_release_chk: assert property (@(posedge clk) disable iff (rst)
      (oe && drive && b_rise && !a_rise) |=> !oe);

   // R5
   dn_release_chk: assert property (@(posedge clk) disable iff (rst)
      (oe && !drive && a_rise && !b_rise) |=> !oe);

   // R7
   coinc_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!oe && a_rise && b_rise) |=> !oe);

   // R8
   drive_idle_chk: assert property (@(posedge clk) disable iff (rst) !oe |-> !drive);

   // R9
   lock_edge_chk: assert property (@(posedge clk) disable iff (rst)
      (!lock && !a_rise && !b_rise) |=> !lock);
endmodule

bind pfd_comparator pfd_comparator_chk u_chk (
   .clk(clk), .rst(rst), .a_rise(fb_rise), .b_rise(ref_rise),
   .oe(pd_oe), .drive(pd_drive), .lock(lock_det)
);

// File: tb/pfd_comparator_bench.sv
module pfd_comparator_bench;
   localparam int WIN_W   = 4;
   localparam int PAIRS   = 4;
   localparam int RUN_MAX = (1 << (WIN_W + 1)) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fb_in = 1'b0, ref_in = 1'b0;
   logic [WIN_W-1:0] win_cfg = '0;
   logic pd_drive, pd_oe, lock_det;

   int checks = 0, errors = 0;
   int hi_cnt = 0, lo_cnt = 0, bad_idle = 0;
   bit measuring = 0;

   always #2.5 clk = ~clk;

   pfd_comparator #(.WIN_W(WIN_W), .LOCK_PAIRS(PAIRS)) u_pfd_comparator (
      .clk(clk), .rst(rst), .fb_in(fb_in), .ref_in(ref_in), .win_cfg(win_cfg),
      .pd_drive(pd_drive), .pd_oe(pd_oe), .lock_det(lock_det)
   );

   // Reference model from the requirements (0 released, 1 high, 2 low)
   bit [1:0] ma_sh, mb_sh;
   bit ma_last, mb_last, m_ra, m_rb, m_close, m_coinc, m_good;
   int m_st = 0, m_nst = 0, m_run = 0, m_cnt = 0;

   function automatic int next_state(int s, bit ra, bit rb);
      if (s == 0) return (ra && !rb) ? 1 : ((rb && !ra) ? 2 : 0);
      if (s == 1) return (rb && !ra) ? 0 : 1;
      return (ra && !rb) ? 0 : 2;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         ma_sh = 0; mb_sh = 0; ma_last = 0; mb_last = 0;
         m_st = 0; m_run = 0; m_cnt = 0;
      end else begin
         m_ra    = ma_sh[1] && !ma_last;
         m_rb    = mb_sh[1] && !mb_last;
         m_nst   = next_state(m_st, m_ra, m_rb);
         m_close = (m_st == 1 && m_rb) || (m_st == 2 && m_ra);
         m_coinc = (m_st == 0) && m_ra && m_rb;
         m_good  = m_coinc || (m_close && m_run <= int'(win_cfg));
         if (m_st != 0 && m_run > int'(win_cfg)) m_cnt = 0;
         else if (m_good && m_cnt < PAIRS)       m_cnt++;
         if (m_nst == 0)                  m_run = 0;
         else if (m_st == 0 || m_close)   m_run = 1;
         else if (m_run < RUN_MAX)        m_run++;
         m_st = m_nst;
         ma_last = ma_sh[1]; mb_last = mb_sh[1];
         ma_sh = {ma_sh[0], fb_in}; mb_sh = {mb_sh[0], ref_in};
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         check("R2 R4 R5 R6 R7 oe", int'(pd_oe), int'(m_st != 0));
         check("R2 R4 R5 R6 drive", int'(pd_drive), int'(m_st == 1));
         check("R9 R10 lock", int'(lock_det), int'(m_cnt == PAIRS));
      end
      if (measuring) begin
         if (pd_oe && pd_drive)  hi_cnt++;
         if (pd_oe && !pd_drive) lo_cnt++;
         if (!pd_oe && pd_drive) bad_idle++;
      end
   end

   // Periodic stimulus: input rises where (t - ph) mod p == 0, high for duty cycles
   task automatic run(int pa, int pha, int da, int pb, int phb, int db,
                      int settle, int meas);
      for (int t = 0; t < settle + meas; t++) begin
         @(negedge clk);
         if (t == settle) begin
            hi_cnt = 0; lo_cnt = 0; measuring = 1;
         end
         fb_in  = (((t - pha) % pa + pa) % pa) < da;
         ref_in = (((t - phb) % pb + pb) % pb) < db;
      end
      @(negedge clk);
      measuring = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1 reset state
      check("R1 oe", int'(pd_oe), 0);
      check("R1 drive", int'(pd_drive), 0);
      check("R1 lock", int'(lock_det), 0);

      // R2: single fb rise; outputs change after the third edge
      @(negedge clk); fb_in = 1;
      repeat (2) @(negedge clk);
      check("R2 early oe", int'(pd_oe), 0);
      @(negedge clk);
      check("R2 R4 oe", int'(pd_oe), 1);
      check("R4 drive high", int'(pd_drive), 1);
      // R3: falling edge leaves drive unchanged
      fb_in = 0;
      repeat (5) @(negedge clk);
      check("R3 fall no effect oe", int'(pd_oe), 1);
      check("R3 fall no effect drive", int'(pd_drive), 1);
      do_reset();

      // R11 R9: feedback leads by 3, window 4
      win_cfg = 4;
      run(16, 0, 8, 16, 3, 8, 160, 160);
      check("R11 lead high cycles", hi_cnt, 30);
      check("R11 lead low cycles", lo_cnt, 0);
      check("R9 lock inside window", int'(lock_det), 1);

      // R10: lead by 6 beyond window 4
      run(16, 0, 8, 16, 6, 8, 160, 160);
      check("R10 lock outside window", int'(lock_det), 0);
      check("R11 lead6 high cycles", hi_cnt, 60);

      // R11 R3: lag by 2, unusual feedback duty
      run(16, 2, 3, 16, 0, 8, 160, 160);
      check("R11 lag low cycles", lo_cnt, 20);
      check("R11 lag high cycles", hi_cnt, 0);
      run(16, 2, 13, 16, 0, 8, 0, 160);
      check("R3 duty independence", lo_cnt, 20);

      // R7 R9: coincident edges with zero window
      win_cfg = 0;
      run(12, 0, 6, 12, 0, 4, 120, 120);
      check("R7 coincident high", hi_cnt, 0);
      check("R7 coincident low", lo_cnt, 0);
      check("R9 coincident lock", int'(lock_det), 1);

      // R10: lock drops when drive outlasts the window
      win_cfg = 2;
      run(12, 0, 6, 12, 5, 6, 60, 60);
      check("R10 lock cleared", int'(lock_det), 0);

      // R11 R5: faster feedback gives only high drive, slower only low
      win_cfg = 4;
      run(10, 0, 5, 14, 0, 7, 140, 280);
      check("R11 fast fb never low", lo_cnt, 0);
      check("R5 R11 fast fb drives high", int'(hi_cnt > 100), 1);
      run(15, 0, 7, 11, 0, 5, 165, 330);
      check("R11 slow fb never high", hi_cnt, 0);
      check("R5 R11 slow fb drives low", int'(lo_cnt > 100), 1);

      // Random toggling checked against the model every cycle
      measuring = 1; bad_idle = 0;
      for (int seg = 0; seg < 8; seg++) begin
         win_cfg = WIN_W'($urandom % 16);
         for (int t = 0; t < 500; t++) begin
            @(negedge clk);
            if ($urandom % 5 == 0) fb_in  = ~fb_in;
            if ($urandom % 5 == 0) ref_in = ~ref_in;
         end
      end
      @(negedge clk);
      measuring = 0;
      check("R8 released implies drive 0", bad_idle, 0);

      // R1: reset while driving
      win_cfg = 4;
      run(16, 0, 8, 16, 3, 8, 100, 0);
      rst = 1;
      @(negedge clk);
      rst = 0;
      check("R1 reset mid-run oe", int'(pd_oe), 0);
      check("R1 reset mid-run lock", int'(lock_det), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule